// File: doc/BRIEF.md
# SPI Command-Decoding Register and Buffer Slave

This block is a serial-peripheral slave that turns short SPI transactions into accesses on a 32-entry byte-wide control-register file and a byte-wide packet buffer. A host lowers chip select, clocks in a command byte, and then clocks further bytes whose meaning depends on that command. Raising chip select ends the transaction. The command byte holds an operation code in its top three bits and a register address in its low five bits. A few complete byte values are reserved for buffer streaming and for a soft reset.

Register reads, register writes and bit-field clears act on one register per transaction. Buffer writes and buffer reads keep streaming bytes for as long as chip select stays low. Each direction has its own pointer, which steps by one per byte and wraps at the buffer depth. One parameterized address range is treated as a slow register class. A read from that range returns one dummy byte before the real value, and a bit-field clear aimed at that range is refused. SCK, MOSI and chip select are sampled in the system clock domain, so SCK must run well below the system clock.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, and whenever chip select is high, MISO is low. Every register reads back as 0x00 after reset.
- R2: A command byte with operation bits 7:5 = 010 stores the next byte into the register given by bits 4:0. Any further bytes in that transaction are ignored.
- R3: A command byte with operation bits 7:5 = 000 sends the addressed register value on MISO, MSB first, in the next byte. For addresses inside the slow class (0x00 to 0x0F by default), the next byte is 0x00 and the value follows in the byte after it.
- R4: A command byte with operation bits 7:5 = 101 uses the next byte as a mask. Every bit that is set in the mask is cleared in the addressed ordinary register, and all other bits are kept.
- R5: The bit-clear operation leaves a slow-class register unchanged.
- R6: Command byte 0x7A writes every following byte to the buffer at the write pointer, which then steps by one. Command byte 0x3A returns buffer bytes from the read pointer, one per following byte, and the pointer steps after each returned byte. Both pointers persist across transactions.
- R7: Both buffer pointers wrap from depth-1 to 0 (depth 16 by default).
- R8: Command byte 0xFF clears every register and both buffer pointers to zero.
- R9: If chip select rises in the middle of a byte, the partial byte has no effect, and the next transaction starts with a fresh command byte.
- R10: Command bytes that match no supported operation (for example, operation bits 100) cause no change to any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all SPI lines |
| rstN | input | 1 | Active-low asynchronous reset |
| spiSck | input | 1 | SPI serial clock, mode 0 |
| spiMosi | input | 1 | Host-to-slave serial data, MSB first |
| spiCsN | input | 1 | Active-low chip select framing each transaction |
| spiMiso | output | 1 | Slave-to-host serial data, MSB first |

## Verification
Register accesses are tried on both an ordinary address and a slow-class address. This separates a missing or misplaced dummy byte from a wrong register value, and it shows whether the bit-clear refusal is limited to the slow class. Buffer streams are split across several transactions to show that the pointers persist, and one stream is longer than the depth to show wrap-around. Other runs include a truncated byte before chip select rises, an unsupported opcode, and soft resets issued after prior traffic. These show that discarded input leaves no trace and that the reset command really returns all state to zero.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;
  localparam int REG_COUNT = 1 << ADDR_W;

  // operation field values (bits 7:5 of the command byte)
  localparam logic [2:0] OP_REG_RD  = 3'b000;
  localparam logic [2:0] OP_REG_WR  = 3'b010;
  localparam logic [2:0] OP_BIT_CLR = 3'b101;

  // whole-byte commands
  localparam logic [7:0] CMD_BUF_RD   = 8'h3A;
  localparam logic [7:0] CMD_BUF_WR   = 8'h7A;
  localparam logic [7:0] CMD_SOFT_RST = 8'hFF;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_RD_DUMMY,
    ST_REG_RD,
    ST_REG_WR,
    ST_REG_CLR,
    ST_BUF_WR,
    ST_BUF_RD,
    ST_SKIP
  } ctrlStateT;

  // strobes from control to datapath, each valid for one clk cycle
  typedef struct packed {
    logic idle;       // chip select high: clear the transmit shifter
    logic shiftTx;    // SCK falling inside a byte: move next bit out
    logic loadReg;    // load addressed register into transmitter
    logic loadDummy;  // load the dummy byte
    logic loadBuf;    // load buffer byte at read pointer
    logic bufRdAdv;   // step read pointer and load the next buffer byte
    logic regWr;      // write received byte into addressed register
    logic regClr;     // clear mask bits in addressed register
    logic bufWr;      // write received byte at write pointer
    logic softRst;    // clear registers and pointers
  } spiStrobeT;

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int MAC_LO = 0,
  parameter int MAC_HI = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              csNIn,
  output spiStrobeT         stb,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] rxByte
);

  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0] sckPipe;
  logic [1:0] mosiPipe;
  logic [1:0] csPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPipe  <= '0;
      mosiPipe <= '0;
      csPipe   <= '1;
    end else begin
      sckPipe  <= {sckPipe[1:0], sckIn};
      mosiPipe <= {mosiPipe[0], mosiIn};
      csPipe   <= {csPipe[0], csNIn};
    end
  end

  logic sckRise, sckFall, mosiS, csHigh;
  assign sckRise = sckPipe[1] & ~sckPipe[2];
  assign sckFall = ~sckPipe[1] & sckPipe[2];
  assign mosiS   = mosiPipe[1];
  assign csHigh  = csPipe[1];

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] rxShift;
  logic              byteDone;

  assign byteDone = !csHigh && sckRise && (bitCnt == CNT_W'(BYTE_W - 1));
  assign rxByte   = {rxShift, mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (csHigh) begin
      bitCnt  <= '0;
    end else if (sckRise) begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= {rxShift[BYTE_W-3:0], mosiS};
    end
  end

  function automatic logic inMacClass(input logic [ADDR_W-1:0] a);
    return (int'(a) >= MAC_LO) && (int'(a) <= MAC_HI);
  endfunction

  ctrlStateT         state, stateNxt;
  logic [ADDR_W-1:0] addrQ;
  logic              cmdMac;

  assign cmdMac  = inMacClass(rxByte[ADDR_W-1:0]);
  assign regAddr = (state == ST_CMD) ? rxByte[ADDR_W-1:0] : addrQ;

  always_comb begin
    stb         = '0;
    stateNxt    = state;
    stb.idle    = csHigh;
    stb.shiftTx = !csHigh && sckFall && (bitCnt != '0);
    if (csHigh) begin
      stateNxt = ST_CMD;
    end else if (byteDone) begin
      unique case (state)
        ST_CMD: begin
          if (rxByte == CMD_SOFT_RST) begin
            stb.softRst = 1'b1;
            stateNxt    = ST_SKIP;
          end else if (rxByte == CMD_BUF_RD) begin
            stb.loadBuf = 1'b1;
            stateNxt    = ST_BUF_RD;
          end else if (rxByte == CMD_BUF_WR) begin
            stateNxt    = ST_BUF_WR;
          end else begin
            unique case (rxByte[7:5])
              OP_REG_RD: begin
                if (cmdMac) begin
                  stb.loadDummy = 1'b1;
                  stateNxt      = ST_RD_DUMMY;
                end else begin
                  stb.loadReg   = 1'b1;
                  stateNxt      = ST_REG_RD;
                end
              end
              OP_REG_WR:  stateNxt = ST_REG_WR;
              OP_BIT_CLR: stateNxt = cmdMac ? ST_SKIP : ST_REG_CLR;
              default:    stateNxt = ST_SKIP;
            endcase
          end
        end
        ST_RD_DUMMY: begin
          stb.loadReg = 1'b1;
          stateNxt    = ST_REG_RD;
        end
        ST_REG_RD:  stateNxt = ST_SKIP;
        ST_REG_WR: begin
          stb.regWr = 1'b1;
          stateNxt  = ST_SKIP;
        end
        ST_REG_CLR: begin
          stb.regClr = 1'b1;
          stateNxt   = ST_SKIP;
        end
        ST_BUF_WR:  stb.bufWr    = 1'b1;
        ST_BUF_RD:  stb.bufRdAdv = 1'b1;
        default:    stateNxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_CMD;
      addrQ <= '0;
    end else begin
      state <= stateNxt;
      if (state == ST_CMD && byteDone) addrQ <= rxByte[ADDR_W-1:0];
    end
  end

  // at most one transmit source per cycle
  AST_ONE_TX_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadReg, stb.loadDummy, stb.loadBuf, stb.bufRdAdv})); // R3

  // a partial byte never produces a write-type strobe once chip select is high
  AST_NO_WRITE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |-> !(stb.regWr || stb.regClr || stb.bufWr || stb.softRst)); // R9

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int MAC_LO    = 0,
  parameter int MAC_HI    = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] rxByte,
  output logic              misoOut
);

  localparam int PTR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  logic [BYTE_W-1:0] regFile [REG_COUNT];
  logic [BYTE_W-1:0] bufMem  [BUF_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, rdPtrNxt;
  logic [BYTE_W-1:0] txShift;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdPtrNxt = stepPtr(rdPtr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (stb.softRst) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (stb.regWr) begin
      regFile[regAddr] <= rxByte;
    end else if (stb.regClr) begin
      regFile[regAddr] <= regFile[regAddr] & ~rxByte;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.bufWr) bufMem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.softRst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.bufWr)    wrPtr <= stepPtr(wrPtr);
      if (stb.bufRdAdv) rdPtr <= rdPtrNxt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              txShift <= '0;
    else if (stb.idle)      txShift <= '0;
    else if (stb.loadReg)   txShift <= regFile[regAddr];
    else if (stb.loadDummy) txShift <= '0;
    else if (stb.loadBuf)   txShift <= bufMem[rdPtr];
    else if (stb.bufRdAdv)  txShift <= bufMem[rdPtrNxt];
    else if (stb.shiftTx)   txShift <= {txShift[BYTE_W-2:0], 1'b0};
  end

  assign misoOut = txShift[BYTE_W-1];

  AST_MISO_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    stb.idle |=> !misoOut); // R1

  AST_NO_SLOW_CLASS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    stb.regClr |-> !((int'(regAddr) >= MAC_LO) && (int'(regAddr) <= MAC_HI))); // R5

  AST_RDPTR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr != $past(rdPtr)) |-> $past(stb.bufRdAdv || stb.softRst)); // R6

  AST_WRPTR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr != $past(wrPtr)) |-> $past(stb.bufWr || stb.softRst)); // R6

  AST_PTRS_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rdPtr) < BUF_DEPTH) && (int'(wrPtr) < BUF_DEPTH)); // R7

  AST_SOFTRST_PTRS: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (rdPtr == '0) && (wrPtr == '0)); // R8

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int MAC_LO    = 0,
  parameter int MAC_HI    = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiSck,
  input  logic spiMosi,
  input  logic spiCsN,
  output logic spiMiso
);

  spiStrobeT         stb;
  logic [ADDR_W-1:0] regAddr;
  logic [BYTE_W-1:0] rxByte;

  spi_cmd_ctrl #(
    .MAC_LO(MAC_LO),
    .MAC_HI(MAC_HI)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .sckIn  (spiSck),
    .mosiIn (spiMosi),
    .csNIn  (spiCsN),
    .stb    (stb),
    .regAddr(regAddr),
    .rxByte (rxByte)
  );

  spi_cmd_dp #(
    .BUF_DEPTH(BUF_DEPTH),
    .MAC_LO   (MAC_LO),
    .MAC_HI   (MAC_HI)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .regAddr(regAddr),
    .rxByte (rxByte),
    .misoOut(spiMiso)
  );

endmodule

// File: tb/spi_cmd_slave_bench.sv
`timescale 1ns/1ps
module spi_cmd_slave_bench;

  localparam int DEPTH  = 16;
  localparam int MAC_LO = 0;
  localparam int MAC_HI = 15;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic csN = 1'b1;
  logic miso;

  always #2.5 clk = ~clk;

  spi_cmd_slave #(.BUF_DEPTH(DEPTH), .MAC_LO(MAC_LO), .MAC_HI(MAC_HI)) u_spi_cmd_slave (
    .clk(clk), .rstN(rstN), .spiSck(sck), .spiMosi(mosi), .spiCsN(csN), .spiMiso(miso)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  logic [7:0] gotQ[$];
  string      reqQ[$];

  // monitor: compares every captured byte against its expectation
  initial begin
    forever begin
      @(negedge clk);
      while (gotQ.size() > 0 && expQ.size() > 0) begin
        logic [7:0] g, e;
        string r;
        g = gotQ.pop_front();
        e = expQ.pop_front();
        r = reqQ.pop_front();
        checks++;
        if (g !== e) begin
          errors++;
          $display("FAIL %s: got 0x%02h expected 0x%02h", r, g, e);
        end
      end
    end
  end

  task automatic checkNow(input logic [7:0] got, input logic [7:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  function automatic bit slowClass(input logic [4:0] a);
    return (int'(a) >= MAC_LO) && (int'(a) <= MAC_HI);
  endfunction

  task automatic csLow();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csRise();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  // driver: one mode-0 byte; queues the sampled MISO byte when chk is set
  task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp, input string req);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    if (chk) begin
      expQ.push_back(exp);
      reqQ.push_back(req);
      gotQ.push_back(rx);
    end
  endtask

  task automatic partialBits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [7:0] d);
    csLow();
    xfer({3'b010, a}, 1'b0, 8'h00, "");
    xfer(d, 1'b0, 8'h00, "");
    csRise();
  endtask

  task automatic regClear(input logic [4:0] a, input logic [7:0] m);
    csLow();
    xfer({3'b101, a}, 1'b0, 8'h00, "");
    xfer(m, 1'b0, 8'h00, "");
    csRise();
  endtask

  task automatic regRead(input logic [4:0] a, input logic [7:0] exp, input string req);
    csLow();
    xfer({3'b000, a}, 1'b0, 8'h00, "");
    if (slowClass(a)) xfer(8'h00, 1'b1, 8'h00, {req, " dummy byte"});
    xfer(8'h00, 1'b1, exp, req);
    csRise();
  endtask

  task automatic softReset();
    csLow();
    xfer(8'hFF, 1'b0, 8'h00, "");
    csRise();
  endtask

  logic [7:0] wrData[$];

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    checkNow({7'd0, miso}, 8'h00, "R1 miso idle");
    regRead(5'h15, 8'h00, "R1 reg after reset");
    regRead(5'h07, 8'h00, "R1 slow reg after reset");

    // R2: ordinary write/read, trailing bytes ignored
    csLow();
    xfer({3'b010, 5'h12}, 1'b0, 8'h00, "");
    xfer(8'hA5, 1'b0, 8'h00, "");
    xfer(8'h3C, 1'b0, 8'h00, "");
    csRise();
    regRead(5'h12, 8'hA5, "R2 write then read 0x12");
    regWrite(5'h1F, 8'h5A);
    regRead(5'h1F, 8'h5A, "R2 write then read 0x1F");

    // R3: slow class read gives dummy then value
    regWrite(5'h03, 8'hC6);
    regRead(5'h03, 8'hC6, "R3 slow class read");
    regWrite(5'h10, 8'h81);
    regRead(5'h10, 8'h81, "R3 first ordinary address no dummy");

    // R4: bit clear on ordinary register
    regClear(5'h12, 8'h0F);
    regRead(5'h12, 8'hA0, "R4 bit clear");

    // R5: bit clear refused on slow class
    regClear(5'h03, 8'hFF);
    regRead(5'h03, 8'hC6, "R5 slow class clear ignored");

    // R10: unsupported opcode 100 has no effect
    csLow();
    xfer({3'b100, 5'h12}, 1'b0, 8'h00, "");
    xfer(8'hFF, 1'b0, 8'h00, "");
    csRise();
    regRead(5'h12, 8'hA0, "R10 unsupported opcode");

    // R9: chip select rises mid-byte
    csLow();
    xfer({3'b010, 5'h12}, 1'b0, 8'h00, "");
    partialBits(8'hFF, 4);
    csRise();
    regRead(5'h12, 8'hA0, "R9 partial data byte dropped");
    csLow();
    partialBits({3'b010, 5'h1F}, 5);
    csRise();
    regRead(5'h1F, 8'h5A, "R9 fresh command after partial");

    // R6: buffer streaming with persistent pointers
    csLow();
    xfer(8'h7A, 1'b0, 8'h00, "");
    foreach (wrData[i]) wrData.delete(i);
    for (int i = 0; i < 5; i++) xfer(8'h11 * (i + 1), 1'b0, 8'h00, "");
    csRise();
    csLow();
    xfer(8'h3A, 1'b0, 8'h00, "");
    for (int i = 0; i < 3; i++) xfer(8'h00, 1'b1, 8'h11 * (i + 1), "R6 buffer read part 1");
    csRise();
    csLow();
    xfer(8'h3A, 1'b0, 8'h00, "");
    for (int i = 3; i < 5; i++) xfer(8'h00, 1'b1, 8'h11 * (i + 1), "R6 buffer read part 2");
    csRise();

    // R8: soft reset clears registers and pointers
    softReset();
    regRead(5'h12, 8'h00, "R8 reg cleared");
    regRead(5'h03, 8'h00, "R8 slow reg cleared");
    csLow();
    xfer(8'h7A, 1'b0, 8'h00, "");
    xfer(8'hAA, 1'b0, 8'h00, "");
    xfer(8'hBB, 1'b0, 8'h00, "");
    csRise();
    csLow();
    xfer(8'h3A, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b1, 8'hAA, "R8 pointers at zero");
    csRise();

    // R7: pointer wrap
    softReset();
    csLow();
    xfer(8'h7A, 1'b0, 8'h00, "");
    for (int i = 0; i < DEPTH + 2; i++) xfer(8'h80 + 8'(i), 1'b0, 8'h00, "");
    csRise();
    csLow();
    xfer(8'h3A, 1'b0, 8'h00, "");
    for (int j = 0; j < DEPTH; j++)
      xfer(8'h00, 1'b1, (j < 2) ? 8'h80 + 8'(DEPTH + j) : 8'h80 + 8'(j), "R7 wrapped write");
    csRise();
    csLow();
    xfer(8'h3A, 1'b0, 8'h00, "");
    xfer(8'h00, 1'b1, 8'h80 + 8'(DEPTH), "R7 wrapped read");
    csRise();

    checkNow({7'd0, miso}, 8'h00, "R1 miso idle at end");
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule